// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block is a clocked controller that connects a simple host request port to an asynchronous byte-wide static RAM. The RAM has a 21-bit address, separate 8-bit data-in and data-out paths with an output-enable for the pad buffer, two chip selects of opposite polarity, an active-low output enable and an active-low write enable. The host offers one access at a time with a valid/ready handshake. It receives a one-cycle done pulse and, for reads, the captured byte.

Each access is split into phases that are counted in clock cycles. Every RAM timing minimum is given in nanoseconds as a parameter, along with the clock period. The controller rounds each minimum up to whole cycles. A write presents the address and data with the device selected, pulses WE low, and then raises WE while data and selects are still held. A read selects the device with OE low, samples the data bus on the last access cycle, and then leaves the bus idle long enough for the RAM's drivers to turn off. Between accesses the RAM rests deselected.

Top module: `sram_ctrl`

## Requirements
- R1: While `req_ready` is high, the RAM rests in standby: `ram_cs_n`=1, `ram_cs`=0, `ram_we_n`=1, `ram_oe_n`=1 and `ram_dq_oe`=0. This is also the state directly after reset.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the access and its recovery are over.
- R3: A write selects the device with WE high for one cycle, then holds `ram_we_n` low for WE_CYC cycles. WE_CYC is the largest of ceil(write-cycle/period), ceil(WE-pulse/period) and ceil(data-setup/period), which is 7 at a 4 ns clock. `ram_oe_n` stays high and the address is stable for the whole write.
- R4: During a write, `ram_dq_oe` is high with the request's data from the select cycle through the cycle after `ram_we_n` rises. The selects stay active in that cycle, so data and address are held across the WE rising edge.
- R5: A read holds the device selected with `ram_we_n`=1, `ram_dq_oe`=0 and `ram_oe_n` low for ACC_CYC = ceil(access/period) cycles, which is 7 at a 4 ns clock.
- R6: `rsp_rdata` takes the value of `ram_dq_in` from the last OE-low cycle. `rsp_done` is high for exactly one cycle, ACC_CYC cycles after the accept edge, and `rsp_rdata` is valid in that same cycle.
- R7: For a write, `rsp_done` pulses for one cycle in the cycle after WE rises, which is 1+WE_CYC cycles after the accept edge.
- R8: After a read, `ram_oe_n` is high and the device is deselected for TURN_CYC = ceil(OE-to-high-Z/period) cycles before `req_ready` returns. This is 2 cycles at a 4 ns clock.
- R9: `ram_dq_oe` is never high while `ram_oe_n` is low. `ram_dq_oe` is low in the cycle before `ram_oe_n` falls.
- R10: `req_valid` while `req_ready` is low is ignored. The current access keeps its own address and no extra `rsp_done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Controller can take an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| ram_addr | output | 21 | RAM address pins |
| ram_cs_n | output | 1 | Active-low chip select |
| ram_cs | output | 1 | Active-high chip select |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |
| ram_dq_out | output | 8 | Data toward the RAM |
| ram_dq_oe | output | 1 | Enable for the data pad driver |
| ram_dq_in | input | 8 | Data from the RAM |

## Verification
Every RAM pin is registered, so the bench counts edges from the accept edge. The select/setup cycle of a write is seen in the first cycle after acceptance. A read's OE is low from that same cycle. The done pulse is due at 1+WE_CYC cycles for writes and at ACC_CYC cycles for reads, and ready returns TURN_CYC cycles after a read's done. The bench records the cycle number of each accept edge in its scoreboard entry and samples every pin on the falling edge, half a cycle after the registers change. It then compares the cycle count of each event with these sums, which it computes from the nanosecond figures and its own clock period.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_WPULSE,
        PH_WHOLD,
        PH_RACCESS,
        PH_RRELEASE
    } phase_e;

    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb rdata_d = capture ? dq_in : rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 21,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_WC_NS       = 25,
    parameter int T_WP_NS       = 18,
    parameter int T_DS_NS       = 12,
    parameter int T_AA_NS       = 25,
    parameter int T_HZOE_NS     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_cs,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);
    // Cycle counts derived from the nanosecond minimums
    localparam int WE_CYC   = imax(1, imax(imax(ns_to_cyc(T_WC_NS, CLK_PERIOD_NS),
                                                ns_to_cyc(T_WP_NS, CLK_PERIOD_NS)),
                                           ns_to_cyc(T_DS_NS, CLK_PERIOD_NS)));
    localparam int ACC_CYC  = imax(1, ns_to_cyc(T_AA_NS, CLK_PERIOD_NS));
    localparam int TURN_CYC = imax(1, ns_to_cyc(T_HZOE_NS, CLK_PERIOD_NS));
    localparam int MAX_CYC  = imax(WE_CYC, imax(ACC_CYC, TURN_CYC));
    localparam int CNT_W    = imax(1, $clog2(MAX_CYC + 1));

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              sel;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              done;
    } ctrl_t;

    ctrl_t            st_d, st_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cap_en;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_en),
        .dq_in   (ram_dq_in),
        .rdata   (rsp_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cap_en    = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.sel   = 1'b1;
                    if (req_write) begin
                        st_d.phase = PH_WSETUP;
                        st_d.dq_oe = 1'b1;
                    end else begin
                        st_d.phase = PH_RACCESS;
                        st_d.oe_n  = 1'b0;
                        tmr_load   = 1'b1;
                        tmr_val    = CNT_W'(ACC_CYC - 1);
                    end
                end
            end
            PH_WSETUP: begin
                st_d.phase = PH_WPULSE;
                st_d.we_n  = 1'b0;
                tmr_load   = 1'b1;
                tmr_val    = CNT_W'(WE_CYC - 1);
            end
            PH_WPULSE: begin
                if (tmr_expired) begin
                    st_d.phase = PH_WHOLD;
                    st_d.we_n  = 1'b1;
                    st_d.done  = 1'b1;
                end
            end
            PH_WHOLD: begin
                st_d.phase = PH_IDLE;
                st_d.sel   = 1'b0;
                st_d.dq_oe = 1'b0;
            end
            PH_RACCESS: begin
                if (tmr_expired) begin
                    cap_en     = 1'b1;
                    st_d.done  = 1'b1;
                    st_d.oe_n  = 1'b1;
                    st_d.sel   = 1'b0;
                    st_d.phase = PH_RRELEASE;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(TURN_CYC - 1);
                end
            end
            PH_RRELEASE: begin
                if (tmr_expired)
                    st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.sel   = 1'b0;
                st_d.oe_n  = 1'b1;
                st_d.we_n  = 1'b1;
                st_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.oe_n  <= 1'b1;
            st_q.we_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = (st_q.phase == PH_IDLE);
    assign rsp_done   = st_q.done;
    assign ram_addr   = st_q.addr;
    assign ram_cs_n   = ~st_q.sel;
    assign ram_cs     = st_q.sel;
    assign ram_oe_n   = st_q.oe_n;
    assign ram_we_n   = st_q.we_n;
    assign ram_dq_out = st_q.wdata;
    assign ram_dq_oe  = st_q.dq_oe;
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8,
    parameter int WE_MIN = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_cs_n,
    input logic              ram_cs,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic [DATA_W-1:0] ram_dq_out,
    input logic              ram_dq_oe
);
    logic [15:0] we_low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            we_low_q <= '0;
        else if (!ram_we_n)
            we_low_q <= (we_low_q == 16'hFFFF) ? we_low_q : we_low_q + 16'd1;
        else
            we_low_q <= '0;
    end

    p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_cs_n && !ram_cs && ram_we_n && ram_oe_n && !ram_dq_oe));

    p_oe_high_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (ram_oe_n && !ram_cs_n && ram_cs && ram_dq_oe));

    p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (we_low_q >= 16'(WE_MIN)));

    p_hold_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (ram_dq_oe && !ram_cs_n && $stable(ram_dq_out) && $stable(ram_addr)));

    p_read_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> (ram_we_n && !ram_cs_n && ram_cs));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n);

    p_release_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_oe_n) |-> !$past(ram_dq_oe));

    p_addr_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));
endmodule

bind sram_ctrl sram_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WE_MIN (WE_CYC)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .ram_addr   (ram_addr),
    .ram_cs_n   (ram_cs_n),
    .ram_cs     (ram_cs),
    .ram_oe_n   (ram_oe_n),
    .ram_we_n   (ram_we_n),
    .ram_dq_out (ram_dq_out),
    .ram_dq_oe  (ram_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;
    localparam int PER = 4;
    localparam int WE_EXP   = 7;  // max(ceil(25/4), ceil(18/4), ceil(12/4))
    localparam int ACC_EXP  = 7;  // ceil(25/4)
    localparam int TURN_EXP = 2;  // ceil(8/4)

    typedef struct {
        bit          w;
        logic [20:0] a;
        logic [7:0]  d;
        int          acc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done, ram_cs_n, ram_cs, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [7:0]  rsp_rdata, ram_dq_out;
    logic [20:0] ram_addr;
    logic [7:0]  ram_dq_in = 8'hC3;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;
    exp_t sbq[$];
    logic [7:0] shadow [logic [20:0]];
    logic [7:0] ram_mem [logic [20:0]];

    always #(PER/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sram_ctrl #(.CLK_PERIOD_NS(PER)) u_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .ram_addr(ram_addr),
        .ram_cs_n(ram_cs_n), .ram_cs(ram_cs), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: issues one access and pushes its expected result
    task automatic issue(input bit w, input logic [20:0] a, input logic [7:0] d);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0;
        e.w = w; e.a = a; e.acc = cyc;
        e.d = w ? d : (shadow.exists(a) ? shadow[a] : 8'h00);
        if (w) shadow[a] = d;
        sbq.push_back(e);
        @(negedge clk);
        chk(req_ready == 1'b0, "R2 ready low after accept", int'(req_ready), 0);
    endtask

    // Request while busy: must be ignored (R10)
    task automatic stray();
        @(negedge clk);
        if (!req_ready) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h0F0F0F; req_wdata = 8'h99;
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor, RAM model and scoreboard
    bit prev_we = 1, prev_oe = 1, prev_dq_oe = 0, prev_sel = 0, prev_done = 0, prev_ready = 1;
    bit last_read = 0;
    int we_low = 0, oe_low = 0, rd_done_cyc = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            automatic bit sel = !ram_cs_n && ram_cs;
            automatic exp_t e;
            if (req_ready)
                chk(ram_cs_n && !ram_cs && ram_we_n && ram_oe_n && !ram_dq_oe,
                    "R1 standby while ready", {ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_dq_oe}, 5'b10110);
            if (sel && sbq.size() > 0 && (prev_sel != sel))
                chk(ram_addr == sbq[0].a, "R10 bus address is accepted one", int'(ram_addr), int'(sbq[0].a));
            if (!ram_we_n) we_low++;
            if (prev_we && !ram_we_n)
                chk(prev_dq_oe && prev_sel && ram_oe_n, "R3 select and data one cycle before WE falls",
                    {prev_dq_oe, prev_sel, ram_oe_n}, 3'b111);
            if (!prev_we && ram_we_n) begin
                chk(we_low == WE_EXP, "R3 WE low width", we_low, WE_EXP);
                chk(ram_dq_oe && sel, "R4 data and selects held after WE rise", {ram_dq_oe, sel}, 2'b11);
                ram_mem[ram_addr] = ram_dq_out;
                we_low = 0;
            end
            if (!ram_oe_n) oe_low++;
            if (prev_oe && !ram_oe_n)
                chk(!prev_dq_oe, "R9 bus released before OE falls", int'(prev_dq_oe), 0);
            if (!prev_oe && ram_oe_n) begin
                chk(oe_low == ACC_EXP, "R5 OE low width", oe_low, ACC_EXP);
                oe_low = 0;
            end
            if (ram_dq_oe)
                chk(ram_oe_n, "R9 no drive while OE low", int'(ram_oe_n), 1);
            if (rsp_done) begin
                chk(!prev_done, "R6 done is one cycle", int'(prev_done), 0);
                if (sbq.size() == 0) begin
                    chk(1'b0, "R10 done without request", 1, 0);
                end else begin
                    e = sbq.pop_front();
                    if (e.w) begin
                        chk(cyc == e.acc + 1 + WE_EXP, "R7 write done timing", cyc - e.acc, 1 + WE_EXP);
                        last_read = 0;
                    end else begin
                        chk(cyc == e.acc + ACC_EXP, "R6 read done timing", cyc - e.acc, ACC_EXP);
                        chk(rsp_rdata == e.d, "R6 read data", int'(rsp_rdata), int'(e.d));
                        last_read = 1;
                        rd_done_cyc = cyc;
                    end
                end
            end
            if (!prev_ready && req_ready && last_read) begin
                chk(cyc - rd_done_cyc == TURN_EXP, "R8 recovery after read", cyc - rd_done_cyc, TURN_EXP);
                last_read = 0;
            end
            // RAM model output for the coming edge
            if (sel && !ram_oe_n && ram_we_n)
                ram_dq_in = ram_mem.exists(ram_addr) ? ram_mem[ram_addr] : 8'h00;
            else
                ram_dq_in = 8'hC3;
            prev_we = ram_we_n; prev_oe = ram_oe_n; prev_dq_oe = ram_dq_oe;
            prev_sel = sel; prev_done = rsp_done; prev_ready = req_ready;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready && ram_cs_n && !ram_cs && ram_we_n && ram_oe_n && !ram_dq_oe,
            "R1 reset state", {req_ready, ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_dq_oe}, 6'b110110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_done, "R1 idle after reset", {req_ready, rsp_done}, 2'b10);

        issue(1, 21'h000000, 8'h00);
        issue(1, 21'h1FFFFF, 8'hFF);
        issue(1, 21'h0A5A5A, 8'hA5);
        issue(1, 21'h155555, 8'h5A);
        issue(0, 21'h1FFFFF, 8'h00);
        issue(0, 21'h000000, 8'h00);
        issue(0, 21'h155555, 8'h00);
        issue(1, 21'h0A5A5A, 8'h3C);   // overwrite
        issue(0, 21'h0A5A5A, 8'h00);   // write then read back-to-back
        issue(0, 21'h000777, 8'h00);   // never written
        stray();                       // R10: request while read busy
        issue(0, 21'h0F0F0F, 8'h00);   // must still read 0
        issue(1, 21'h000001, 8'hC3);
        stray();                       // R10: request while write busy
        issue(0, 21'h000001, 8'h00);
        issue(0, 21'h0F0F0F, 8'h00);

        while (sbq.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(sbq.size() == 0 && req_ready, "R10 no pending or extra work", sbq.size(), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule